// File: doc/BRIEF.md
# Acquisition Card Port Register Interface

This block sits behind a 16-byte I/O port window on a multifunction acquisition card. It decodes the port offset and reaches a shared digital input/output word, a DAC data port, an ADC convert/data port, a combined status/control word, a clock divider word, and a pair of encoder ports. The encoder ports go unchanged to a separate counter block.

Software first writes the control word to pick a channel. Bit 6 of that word (enable) starts a settling interval. Software then writes the ADC port to start a conversion and polls status until the conversion flag is set. It then reads the ADC port twice to get the sample, high byte first. A converter stub inside the block holds off the completion flag for a parameterised number of cycles. It then captures the 13-bit two's complement sample of the chosen analog input.

A DAC update takes three writes. The first sets the two-bit load field of the control word to 3 along with the channel. The second writes the 12-bit value to the DAC port. The third clears the control word.

Top module: `daq_regif`

## Requirements
- R1: After reset, dout_o, ctrl_o, clk_div_o, every DAC latch and dac_load_o are zero. Both status flags read 0. The ADC byte pointer selects the high byte, and the stored sample is zero.
- R2: A write to offset 0x00 sets dout_o to the written word on the next cycle. A read of 0x00 always returns din_i and never the output word.
- R3: A write to offset 0x06 stores wdata bits 12:0 into ctrl_o, and bits 15:13 are dropped. The fields are: bits 2:0 select the DAC channel, bits 5:3 select the ADC or encoder channel, bit 6 is enable, bits 12:11 are the load field.
- R4: Status bit 3 (settled), read at offset 0x06, is cleared by every control write. If the written bit 6 is 1, the bit reads 1 from SETTLE_CYC cycles after the write. If bit 6 is 0, it stays 0 until the next control write.
- R5: A write to offset 0x04 starts a conversion and clears status bit 4 (done) on the next cycle. Bit 4 reads 1 from CONV_CYC cycles after the start. The sample is then the analog input selected by control bits 5:3 at the start, masked to 13 bits and zero-extended.
- R6: Reads of offset 0x04 return one byte in rdata bits 7:0, with bits 15:8 at zero. The bytes alternate: first sample bits 15:8, then bits 7:0. Every conversion start resets the pointer to the high byte.
- R7: A write to offset 0x02 while the load field equals 3 does two things on the next cycle. It stores wdata bits 11:0 into the DAC latch chosen by control bits 2:0. It raises only that channel's bit of dac_load_o for one cycle.
- R8: A write to offset 0x02 while the load field is not 3 changes no DAC latch and raises no dac_load_o bit.
- R9: A write to offset 0x08 sets clk_div_o to the written word, and a read of 0x08 returns it.
- R10: An access to 0x0C or 0x0E raises enc_wr_o or enc_rd_o in the same cycle. enc_cmd_o is 1 for 0x0E and 0 for 0x0C, and enc_wdata_o carries wdata bits 7:0. A read returns enc_rdata_i in bits 7:0.
- R11: Odd offsets and offset 0x0A read 0, and writes to them change no output or register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Port offset within the window |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid while rd_i is high, else 0 |
| din_i | input | DIO_W | Digital input pins |
| dout_o | output | DIO_W | Digital output word |
| ctrl_o | output | 13 | Control word fields |
| ain_i | input | N_AI x AI_W | Converter stub analog samples, one per channel |
| dac_val_o | output | N_AO x AO_W | DAC channel latches |
| dac_load_o | output | N_AO | One-cycle load strobe per DAC channel |
| clk_div_o | output | 16 | Clock divider word |
| enc_wr_o | output | 1 | Encoder port write strobe |
| enc_rd_o | output | 1 | Encoder port read strobe |
| enc_cmd_o | output | 1 | 1 for the command port, 0 for the data port |
| enc_wdata_o | output | 8 | Encoder write byte |
| enc_rdata_i | input | 8 | Encoder read byte |

## Verification
The bench builds the block with SETTLE_CYC = 3 and CONV_CYC = 5. These short delays let status be polled on every cycle across both the settling and conversion windows, so the exact rise cycle of each flag is compared. The other widths stay at their defaults, which gives full 8-channel DAC and ADC selection. Samples with bits set above bit 12 and with the sign bit set show the 13-bit mask. An abandoned byte sequence followed by a new conversion shows the pointer returning to the high byte.

// File: rtl/daq_regif_pkg.sv
package daq_regif_pkg;
  // word index = addr[3:1]
  localparam logic [2:0] IDX_DIO  = 3'd0;
  localparam logic [2:0] IDX_DAC  = 3'd1;
  localparam logic [2:0] IDX_ADC  = 3'd2;
  localparam logic [2:0] IDX_CSR  = 3'd3;
  localparam logic [2:0] IDX_CLK  = 3'd4;
  localparam logic [2:0] IDX_ENCD = 3'd6;
  localparam logic [2:0] IDX_ENCC = 3'd7;

  localparam int CTRL_W      = 13;
  localparam int CTRL_AO_LSB = 0;
  localparam int CTRL_CH_LSB = 3;
  localparam int CTRL_EN     = 6;
  localparam int CTRL_LD_LSB = 11;
  localparam int STAT_SETTLED = 3;
  localparam int STAT_DONE    = 4;

  typedef struct packed {
    logic dio;
    logic dac;
    logic adc;
    logic csr;
    logic clk;
    logic encd;
    logic encc;
  } port_sel_t;
endpackage

// File: rtl/daq_port_dec.sv
module daq_port_dec
  import daq_regif_pkg::*;
(
  input  logic [3:0] addr_i,
  output port_sel_t  sel_o
);
  always_comb begin
    sel_o = '0;
    if (!addr_i[0]) begin
      unique case (addr_i[3:1])
        IDX_DIO:  sel_o.dio  = 1'b1;
        IDX_DAC:  sel_o.dac  = 1'b1;
        IDX_ADC:  sel_o.adc  = 1'b1;
        IDX_CSR:  sel_o.csr  = 1'b1;
        IDX_CLK:  sel_o.clk  = 1'b1;
        IDX_ENCD: sel_o.encd = 1'b1;
        IDX_ENCC: sel_o.encc = 1'b1;
        default:  sel_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/daq_adc_seq.sv
module daq_adc_seq #(
  parameter int N_AI       = 8,
  parameter int AI_W       = 13,
  parameter int SETTLE_CYC = 4,
  parameter int CONV_CYC   = 16,
  localparam int SEL_W = $clog2(N_AI),
  localparam int SW    = $clog2(SETTLE_CYC + 1),
  localparam int CW    = $clog2(CONV_CYC + 1)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           ctrl_wr_i,
  input  logic                           en_i,
  input  logic                           start_i,
  input  logic                           byte_rd_i,
  input  logic [SEL_W-1:0]               chan_i,
  input  logic [N_AI-1:0][AI_W-1:0]      ain_i,
  output logic                           settled_o,
  output logic                           done_o,
  output logic [7:0]                     byte_o
);
  logic [SW-1:0]    settle_cnt;
  logic [CW-1:0]    conv_cnt;
  logic [SEL_W-1:0] chan_q;
  logic [15:0]      res_q;
  logic             hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      settle_cnt <= '0;
      settled_o  <= 1'b0;
    end else if (ctrl_wr_i) begin
      settled_o  <= 1'b0;
      settle_cnt <= en_i ? SW'(SETTLE_CYC) : '0;
    end else if (settle_cnt != '0) begin
      settle_cnt <= settle_cnt - SW'(1);
      if (settle_cnt == SW'(1)) settled_o <= 1'b1;
    end
  end

  // converter stub: fixed latency, sample taken at completion
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conv_cnt <= '0;
      done_o   <= 1'b0;
      chan_q   <= '0;
      res_q    <= '0;
    end else if (start_i) begin
      conv_cnt <= CW'(CONV_CYC);
      done_o   <= 1'b0;
      chan_q   <= chan_i;
    end else if (conv_cnt != '0) begin
      conv_cnt <= conv_cnt - CW'(1);
      if (conv_cnt == CW'(1)) begin
        done_o <= 1'b1;
        res_q  <= 16'(ain_i[chan_q]);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hi_q <= 1'b1;
    else if (start_i)   hi_q <= 1'b1;
    else if (byte_rd_i) hi_q <= ~hi_q;
  end

  assign byte_o = hi_q ? res_q[15:8] : res_q[7:0];
endmodule

// File: rtl/daq_dac_bank.sv
module daq_dac_bank #(
  parameter int N_AO = 8,
  parameter int AO_W = 12,
  localparam int SEL_W = $clog2(N_AO)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_i,
  input  logic [SEL_W-1:0]          sel_i,
  input  logic [AO_W-1:0]           data_i,
  output logic [N_AO-1:0][AO_W-1:0] val_o,
  output logic [N_AO-1:0]           load_o
);
  for (genvar g = 0; g < N_AO; g++) begin : g_ch
    logic hit;
    assign hit = wr_i && (sel_i == SEL_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_o[g]  <= '0;
        load_o[g] <= 1'b0;
      end else begin
        load_o[g] <= hit;
        if (hit) val_o[g] <= data_i;
      end
    end
  end
endmodule

// File: rtl/daq_regif.sv
module daq_regif
  import daq_regif_pkg::*;
#(
  parameter int N_AI       = 8,
  parameter int N_AO       = 8,
  parameter int DIO_W      = 16,
  parameter int AI_W       = 13,
  parameter int AO_W       = 12,
  parameter int SETTLE_CYC = 4,
  parameter int CONV_CYC   = 16,
  localparam int AI_SEL_W = $clog2(N_AI),
  localparam int AO_SEL_W = $clog2(N_AO)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [3:0]                addr_i,
  input  logic                      wr_i,
  input  logic                      rd_i,
  input  logic [15:0]               wdata_i,
  output logic [15:0]               rdata_o,
  input  logic [DIO_W-1:0]          din_i,
  output logic [DIO_W-1:0]          dout_o,
  output logic [CTRL_W-1:0]         ctrl_o,
  input  logic [N_AI-1:0][AI_W-1:0] ain_i,
  output logic [N_AO-1:0][AO_W-1:0] dac_val_o,
  output logic [N_AO-1:0]           dac_load_o,
  output logic [15:0]               clk_div_o,
  output logic                      enc_wr_o,
  output logic                      enc_rd_o,
  output logic                      enc_cmd_o,
  output logic [7:0]                enc_wdata_o,
  input  logic [7:0]                enc_rdata_i
);
  port_sel_t  sel;
  logic       settled, done;
  logic [7:0] adc_byte;
  logic [15:0] stat;
  logic       dac_wr;

  daq_port_dec u_dec (.addr_i(addr_i), .sel_o(sel));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_o    <= '0;
      ctrl_o    <= '0;
      clk_div_o <= '0;
    end else if (wr_i) begin
      if (sel.dio) dout_o    <= wdata_i[DIO_W-1:0];
      if (sel.csr) ctrl_o    <= wdata_i[CTRL_W-1:0];
      if (sel.clk) clk_div_o <= wdata_i;
    end
  end

  assign dac_wr = wr_i && sel.dac && (ctrl_o[CTRL_LD_LSB +: 2] == 2'b11);

  daq_dac_bank #(.N_AO(N_AO), .AO_W(AO_W)) u_dac (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (dac_wr),
    .sel_i  (ctrl_o[CTRL_AO_LSB +: AO_SEL_W]),
    .data_i (wdata_i[AO_W-1:0]),
    .val_o  (dac_val_o),
    .load_o (dac_load_o)
  );

  daq_adc_seq #(
    .N_AI(N_AI), .AI_W(AI_W), .SETTLE_CYC(SETTLE_CYC), .CONV_CYC(CONV_CYC)
  ) u_adc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_wr_i (wr_i && sel.csr),
    .en_i      (wdata_i[CTRL_EN]),
    .start_i   (wr_i && sel.adc),
    .byte_rd_i (rd_i && sel.adc),
    .chan_i    (ctrl_o[CTRL_CH_LSB +: AI_SEL_W]),
    .ain_i     (ain_i),
    .settled_o (settled),
    .done_o    (done),
    .byte_o    (adc_byte)
  );

  always_comb begin
    stat = '0;
    stat[STAT_SETTLED] = settled;
    stat[STAT_DONE]    = done;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (sel.dio)             rdata_o = 16'(din_i);
      if (sel.adc)             rdata_o = {8'h00, adc_byte};
      if (sel.csr)             rdata_o = stat;
      if (sel.clk)             rdata_o = clk_div_o;
      if (sel.encd | sel.encc) rdata_o = {8'h00, enc_rdata_i};
    end
  end

  assign enc_wr_o    = wr_i && (sel.encd || sel.encc);
  assign enc_rd_o    = rd_i && (sel.encd || sel.encc);
  assign enc_cmd_o   = sel.encc;
  assign enc_wdata_o = wdata_i[7:0];
endmodule

// File: rtl/daq_regif_chk.sv
module daq_regif_chk #(
  parameter int N_AO  = 8,
  parameter int DIO_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [3:0]        addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [15:0]       wdata_i,
  input logic [15:0]       rdata_o,
  input logic [DIO_W-1:0]  dout_o,
  input logic [12:0]       ctrl_o,
  input logic [N_AO-1:0]   dac_load_o
);
  assert_load_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dac_load_o));

  assert_load_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dac_load_o != '0) |-> $past(wr_i && addr_i == 4'h2));

  assert_load_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 4'h2 && ctrl_o[12:11] != 2'b11) |=> (dac_load_o == '0));

  assert_ctrl_store_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 4'h6) |=> (ctrl_o == $past(wdata_i[12:0])));

  assert_dout_store_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 4'h0) |=> (dout_o == $past(wdata_i[DIO_W-1:0])));

  assert_done_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 4'h4) |=> !(rd_i && addr_i == 4'h6 && rdata_o[4]));
endmodule

bind daq_regif daq_regif_chk #(.N_AO(N_AO), .DIO_W(DIO_W)) u_chk (.*);

// File: tb/tb_daq_regif.sv
module tb_daq_regif;
  localparam int ST = 3;
  localparam int CV = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [3:0]       addr = '0;
  logic             wr = 1'b0, rd = 1'b0;
  logic [15:0]      wdata = '0;
  logic [15:0]      rdata;
  logic [15:0]      din = '0;
  logic [15:0]      dout;
  logic [12:0]      ctrl;
  logic [7:0][12:0] ain = '0;
  logic [7:0][11:0] dac_val;
  logic [7:0]       dac_load;
  logic [15:0]      clk_div;
  logic             enc_wr, enc_rd, enc_cmd;
  logic [7:0]       enc_wdata;
  logic [7:0]       enc_rdata = '0;

  daq_regif #(.SETTLE_CYC(ST), .CONV_CYC(CV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .din_i(din), .dout_o(dout),
    .ctrl_o(ctrl), .ain_i(ain), .dac_val_o(dac_val), .dac_load_o(dac_load),
    .clk_div_o(clk_div), .enc_wr_o(enc_wr), .enc_rd_o(enc_rd),
    .enc_cmd_o(enc_cmd), .enc_wdata_o(enc_wdata), .enc_rdata_i(enc_rdata)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;
  string phase = "R1";

  // behavioural reference model
  logic [15:0] m_dout, m_clk, m_res;
  logic [12:0] m_ctrl;
  logic [11:0] m_dac [8];
  logic [7:0]  m_load;
  int m_scnt, m_ccnt, m_ch;
  bit m_set, m_done, m_hi;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dout = 0; m_clk = 0; m_res = 0; m_ctrl = 0; m_load = 0;
      for (int i = 0; i < 8; i++) m_dac[i] = 0;
      m_scnt = 0; m_ccnt = 0; m_ch = 0; m_set = 0; m_done = 0; m_hi = 1;
    end else begin
      m_load = 0;
      if (wr && addr == 4'h2 && m_ctrl[12:11] == 2'b11) begin
        m_dac[m_ctrl[2:0]] = wdata[11:0];
        m_load = 8'(1) << m_ctrl[2:0];
      end
      if (wr && addr == 4'h4) begin
        m_ccnt = CV; m_done = 0; m_hi = 1; m_ch = int'(m_ctrl[5:3]);
      end else begin
        if (m_ccnt > 0) begin
          m_ccnt--;
          if (m_ccnt == 0) begin m_done = 1; m_res = {3'b000, ain[m_ch]}; end
        end
        if (rd && addr == 4'h4) m_hi = !m_hi;
      end
      if (wr && addr == 4'h6) begin
        m_ctrl = wdata[12:0]; m_set = 0; m_scnt = wdata[6] ? ST : 0;
      end else if (m_scnt > 0) begin
        m_scnt--;
        if (m_scnt == 0) m_set = 1;
      end
      if (wr && addr == 4'h0) m_dout = wdata;
      if (wr && addr == 4'h8) m_clk = wdata;
    end
  end

  function automatic logic [15:0] exp_rdata();
    if (!rd) return 16'h0;
    case (addr)
      4'h0: return din;
      4'h4: return m_hi ? {8'h00, m_res[15:8]} : {8'h00, m_res[7:0]};
      4'h6: return {11'h0, m_done, m_set, 3'b000};
      4'h8: return m_clk;
      4'hC, 4'hE: return {8'h00, enc_rdata};
      default: return 16'h0;
    endcase
  endfunction

  function automatic string rd_tag();
    case (addr)
      4'h0: return "R2";
      4'h4: return "R6 R5";
      4'h6: return "R4 R5";
      4'h8: return "R9";
      4'hC, 4'hE: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s [%s] t=%0t actual=%h expected=%h", tag, phase, $time, act, exp);
    end
  endtask

  task automatic tick();
    #1;
    chk({rd_tag(), " rdata"}, 32'(rdata), 32'(exp_rdata()));
    chk("R2 dout", 32'(dout), 32'(m_dout));
    chk("R3 ctrl", 32'(ctrl), 32'(m_ctrl));
    chk("R9 clk_div", 32'(clk_div), 32'(m_clk));
    chk("R7 R8 dac_load", 32'(dac_load), 32'(m_load));
    for (int i = 0; i < 8; i++) chk("R7 R8 dac_val", 32'(dac_val[i]), 32'(m_dac[i]));
    chk("R10 enc_wr", 32'(enc_wr), 32'(wr && (addr == 4'hC || addr == 4'hE)));
    chk("R10 enc_rd", 32'(enc_rd), 32'(rd && (addr == 4'hC || addr == 4'hE)));
    if (wr || rd) begin
      if (addr == 4'hC || addr == 4'hE) begin
        chk("R10 enc_cmd", 32'(enc_cmd), 32'(addr == 4'hE));
        chk("R10 enc_wdata", 32'(enc_wdata), 32'(wdata[7:0]));
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr = 1'b1; tick(); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a);
    addr = a; rd = 1'b1; tick(); rd = 1'b0;
  endtask

  task automatic poll(input int n);
    for (int i = 0; i < n; i++) bus_rd(4'h6);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); tick(); tick();
    rst_n = 1'b1;
    phase = "R1";
    idle(2); bus_rd(4'h6); bus_rd(4'h4); bus_rd(4'h4);

    phase = "R2";
    din = 16'hA5C3; bus_rd(4'h0);
    bus_wr(4'h0, 16'h1234); bus_rd(4'h0);
    din = 16'h0F0F; bus_rd(4'h0);

    phase = "R3";
    bus_wr(4'h6, 16'hFFFF); idle(1);

    phase = "R4 enable";
    poll(ST + 2);
    phase = "R4 no enable";
    bus_wr(4'h6, 16'h0000); poll(ST + 3);

    phase = "R5 chan5";
    ain[5] = 13'h1ABC; ain[2] = 13'h1123; ain[0] = 13'h0042;
    bus_wr(4'h6, 16'h0040 | (16'd5 << 3)); poll(ST + 1);
    bus_wr(4'h4, 16'h0000); poll(CV + 1);
    phase = "R6 byte order";
    bus_rd(4'h4); bus_rd(4'h4); bus_rd(4'h4);

    phase = "R5 chan2 select latched";
    bus_wr(4'h6, 16'h0040 | (16'd2 << 3));
    bus_wr(4'h4, 16'h0000);
    bus_wr(4'h6, 16'h0040);
    poll(CV);
    phase = "R6 pointer reset";
    bus_rd(4'h4);
    bus_wr(4'h4, 16'h0000); idle(CV); bus_rd(4'h4); bus_rd(4'h4);

    phase = "R7 load";
    bus_wr(4'h6, (16'd3 << 11) | 16'd6); bus_wr(4'h2, 16'hABCD); idle(1);
    bus_wr(4'h6, (16'd3 << 11) | 16'd0); bus_wr(4'h2, 16'h0123);
    bus_wr(4'h2, 16'h0456); idle(1);
    phase = "R8 ignored";
    bus_wr(4'h6, 16'h0000); bus_wr(4'h2, 16'h0777); idle(1);
    bus_wr(4'h6, (16'd2 << 11) | 16'd1); bus_wr(4'h2, 16'h0888); idle(1);
    bus_wr(4'h6, (16'd1 << 11) | 16'd3); bus_wr(4'h2, 16'h0999); idle(1);

    phase = "R9";
    bus_wr(4'h8, 16'h55AA); bus_rd(4'h8);

    phase = "R10";
    enc_rdata = 8'h3C;
    bus_wr(4'hC, 16'h01FF); bus_wr(4'hE, 16'h0001);
    bus_rd(4'hC); enc_rdata = 8'hC7; bus_rd(4'hE);

    phase = "R11";
    bus_wr(4'hA, 16'hFFFF); bus_rd(4'hA);
    bus_wr(4'h1, 16'hFFFF); bus_wr(4'h7, 16'hFFFF); bus_wr(4'h5, 16'hFFFF);
    bus_rd(4'h1); bus_rd(4'h5); bus_rd(4'h7); bus_rd(4'hB);
    bus_rd(4'h6); bus_rd(4'h0); bus_rd(4'h4);
    idle(2);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule